// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block carries a single data word from a writer running on one clock to a reader running on another clock. It sits beside a FIFO data path and bypasses it. The writer deposits a word with a strobe qualified by its mailbox select. The reader receives the word through its output selector, which shows either the mailbox contents or the FIFO output register, depending on the reader's mailbox select.

An active-low mail flag forms a one-deep handshake.

- An accepted write lowers the flag in the writer's domain. From then on the mailbox refuses further writes.
- The reader sees the flag go low once the set event has passed through a two-flop synchroniser.
- A qualified read returns the reader's flag high immediately.
- The writer sees the flag return high after the clear event has been synchronised back into its domain.

The same reset that clears the associated FIFO puts both views of the flag in their idle (high) state.

Top module: `mailbox_xclk`

## Requirements
- R1: While `rst` is high, `wr_mail_n` and `rd_mail_n` are both 1 (no mail pending).
- R2: A `wr_clk` rising edge with `wr_en`=1, `wr_sel`=1 and `wr_mail_n`=1 is an accepted write. It stores `wr_data` and drives `wr_mail_n` to 0 at that same edge.
- R3: A write strobe while `wr_mail_n` is 0 is ignored, and the stored word is unchanged.
- R4: After an accepted write, `rd_mail_n` goes to 0 within three `rd_clk` rising edges.
- R5: A `rd_clk` rising edge with `rd_en`=1, `rd_sel`=1 and `rd_mail_n`=0 drives `rd_mail_n` to 1 at that edge.
- R6: After such a read, `wr_mail_n` returns to 1 within three `wr_clk` rising edges.
- R7: A read with `rd_sel`=1 while `rd_mail_n` is 1 leaves the flag at 1, and `rd_dout` still shows the last stored word.
- R8: `rd_dout` equals the stored mailbox word when `rd_sel`=1, and equals `fifo_q` when `rd_sel`=0.
- R9: A strobe with its select at 0 affects neither flag. This holds for `wr_en` with `wr_sel`=0 and for `rd_en` with `rd_sel`=0.
- R10: The stored word stays stable from the moment the reader sees mail pending until the reader clears it.
- R11: Every word written in sequence reaches the reader intact and in order, with each word waiting for the previous one to be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset for both domains |
| wr_clk | input | 1 | Writer clock |
| wr_en | input | 1 | Writer strobe |
| wr_sel | input | 1 | Writer mailbox select |
| wr_data | input | WIDTH | Word to deposit |
| wr_mail_n | output | 1 | Mail flag in the writer's domain, 0 = pending |
| rd_clk | input | 1 | Reader clock |
| rd_en | input | 1 | Reader strobe |
| rd_sel | input | 1 | Reader mailbox select, also steers the output selector |
| fifo_q | input | WIDTH | FIFO output register contents |
| rd_dout | output | WIDTH | Selected output word |
| rd_mail_n | output | 1 | Mail flag in the reader's domain, 0 = pending |

## Verification
The failures that matter most are internal toggle or synchroniser state that disagrees between the two domains. Such a mismatch shows at the ports as a flag that never falls or never rises, and the bench bounds each crossing to three edges so that a lost event is detected within a few cycles. A capture enable that ignores the pending flag surfaces as the wrong word on `rd_dout` at the next mailbox read. A clear that fires without pending mail shows as a flag falling when nothing was written.

// File: rtl/mailbox_xclk.sv
module mailbox_xclk #(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst,
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_mail_n,
  input  logic             rd_clk,
  input  logic             rd_en,
  input  logic             rd_sel,
  input  logic [WIDTH-1:0] fifo_q,
  output logic [WIDTH-1:0] rd_dout,
  output logic             rd_mail_n
);

  localparam int LAST = SYNC_STAGES - 1;

  logic                   set_tgl, clr_tgl;
  logic [SYNC_STAGES-1:0] set_sync, clr_sync;
  logic [WIDTH-1:0]       mail_q;
  logic                   wr_take, rd_take;

  assign wr_mail_n = ~(set_tgl ^ clr_sync[LAST]);
  assign rd_mail_n = ~(set_sync[LAST] ^ clr_tgl);
  assign wr_take   = wr_en & wr_sel & wr_mail_n;
  assign rd_take   = rd_en & rd_sel & ~rd_mail_n;
  assign rd_dout   = rd_sel ? mail_q : fifo_q;

  always_ff @(posedge wr_clk or posedge rst) begin
    if (rst) begin
      set_tgl  <= 1'b0;
      clr_sync <= '0;
      mail_q   <= '0;
    end else begin
      clr_sync <= {clr_sync[LAST-1:0], clr_tgl};
      if (wr_take) begin
        set_tgl <= ~set_tgl;
        mail_q  <= wr_data;
      end
    end
  end

  always_ff @(posedge rd_clk or posedge rst) begin
    if (rst) begin
      clr_tgl  <= 1'b0;
      set_sync <= '0;
    end else begin
      set_sync <= {set_sync[LAST-1:0], set_tgl};
      if (rd_take) clr_tgl <= ~clr_tgl;
    end
  end

  // R1
  idle_after_reset_chk: assert property (@(posedge wr_clk) rst |=> wr_mail_n);

  // R2
  write_sets_flag_chk: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en && wr_sel && wr_mail_n) |=> !wr_mail_n);

  // R3
  blocked_write_chk: assert property (@(posedge wr_clk) disable iff (rst)
    (!wr_mail_n && wr_en && wr_sel) |=> $stable(mail_q));

  // R5
  read_clears_flag_chk: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_en && rd_sel && !rd_mail_n) |=> rd_mail_n);

  // R10
  pending_data_stable_chk: assert property (@(posedge rd_clk) disable iff (rst)
    (!rd_mail_n && !(rd_en && rd_sel)) |=> $stable(mail_q));

endmodule

// File: tb/mailbox_xclk_tb.sv
module mailbox_xclk_tb;
  localparam int W = 36;

  logic         rst = 1'b1;
  logic         wr_clk = 1'b0, rd_clk = 1'b0;
  logic         wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] wr_data = '0, fifo_q = '0;
  logic [W-1:0] rd_dout;
  logic         wr_mail_n, rd_mail_n;

  int errors = 0, checks = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] lcg = 36'h0_1234_5678;
  int received = 0;

  always #4 wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  mailbox_xclk #(.WIDTH(W)) u_dut (
    .rst(rst), .wr_clk(wr_clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_mail_n(wr_mail_n), .rd_clk(rd_clk), .rd_en(rd_en), .rd_sel(rd_sel),
    .fifo_q(fifo_q), .rd_dout(rd_dout), .rd_mail_n(rd_mail_n));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic post_word(input logic [W-1:0] w);
    while (!wr_mail_n) @(negedge wr_clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = w;
    exp_q.push_back(w);
    @(negedge wr_clk);
    chk(wr_mail_n == 1'b0, "R2", {35'd0, wr_mail_n}, 36'd0);
    wr_data = ~w;
    @(negedge wr_clk);
    wr_en = 1'b0; wr_sel = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic [W-1:0] w1;
    repeat (3) @(negedge wr_clk);
    chk(wr_mail_n == 1'b1, "R1 wr", {35'd0, wr_mail_n}, 36'd1);
    chk(rd_mail_n == 1'b1, "R1 rd", {35'd0, rd_mail_n}, 36'd1);
    @(negedge wr_clk); rst = 1'b0;
    @(negedge rd_clk);
    // R8 FIFO path
    fifo_q = 36'hA_5A5A_5A5A; #1;
    chk(rd_dout == 36'hA_5A5A_5A5A, "R8 fifo", rd_dout, 36'hA_5A5A_5A5A);
    fifo_q = 36'h3_0F0F_0F0F; #1;
    chk(rd_dout == 36'h3_0F0F_0F0F, "R8 fifo", rd_dout, 36'h3_0F0F_0F0F);
    // R9 writer strobe without select
    @(negedge wr_clk); wr_en = 1'b1; wr_data = 36'hF_FFFF_FFFF;
    @(negedge wr_clk); wr_en = 1'b0;
    chk(wr_mail_n == 1'b1, "R9 wr", {35'd0, wr_mail_n}, 36'd1);
    // R2 / R3
    w1 = 36'h9_8765_4321;
    post_word(w1);
    void'(exp_q.pop_front());
    // R4
    n = 0;
    while (rd_mail_n && n < 8) begin @(negedge rd_clk); n++; end
    chk(!rd_mail_n && n <= 3, "R4", n, 3);
    // R9 reader strobe without select
    rd_en = 1'b1; rd_sel = 1'b0;
    @(negedge rd_clk); rd_en = 1'b0;
    chk(rd_mail_n == 1'b0, "R9 rd", {35'd0, rd_mail_n}, 36'd0);
    // R3 / R10 / R8 mailbox path
    rd_sel = 1'b1; #1;
    chk(rd_dout == w1, "R3 R8 R10", rd_dout, w1);
    rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
    chk(rd_mail_n == 1'b1, "R5", {35'd0, rd_mail_n}, 36'd1);
    // R6
    n = 0;
    @(negedge wr_clk);
    while (!wr_mail_n && n < 8) begin @(negedge wr_clk); n++; end
    chk(wr_mail_n && n <= 3, "R6", n, 3);
    // R7
    @(negedge rd_clk); rd_en = 1'b1; rd_sel = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
    chk(rd_mail_n == 1'b1, "R7 flag", {35'd0, rd_mail_n}, 36'd1);
    chk(rd_dout == w1, "R7 data", rd_dout, w1);
    rd_sel = 1'b0;
    // R11 scoreboard
    fork
      begin
        for (int i = 0; i < 20; i++) begin
          lcg = lcg * 36'd1103515245 + 36'd12345;
          post_word(lcg);
        end
      end
      begin
        while (received < 20) begin
          @(negedge rd_clk);
          if (!rd_mail_n) begin
            rd_sel = 1'b1; #1;
            if (exp_q.size() == 0) chk(1'b0, "R11 empty", rd_dout, '0);
            else begin
              logic [W-1:0] e;
              e = exp_q.pop_front();
              chk(rd_dout == e, "R11", rd_dout, e);
            end
            rd_en = 1'b1;
            @(negedge rd_clk); rd_en = 1'b0; rd_sel = 1'b0;
            chk(rd_mail_n == 1'b1, "R5", {35'd0, rd_mail_n}, 36'd1);
            received++;
          end
        end
      end
    join
    chk(exp_q.size() == 0, "R11 drain", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule